// File: doc/BRIEF.md
# Endpoint Handshake and STALL Control

This block picks the handshake that answers each token arriving on one endpoint and keeps the state behind that choice. The state is a pending STALL request, a flag recording that a STALL went out, a flag for an accepted SETUP, and a flag for accepted OUT data. Firmware arms and disarms the STALL request with two strobes. The token decoder reports each token as a one-cycle event with its kind, alongside a retry-required signal from the buffer logic. A configuration bit marks the endpoint as a control endpoint.

The design makes its decision from the state held before the token's cycle. The chosen handshake shows on the outputs one clock after the token, and the flags update on that same edge. A SETUP is always accepted. On a control endpoint a SETUP also cancels a pending STALL, so firmware can reject an unsupported request and wait for the next SETUP without tracking anything. A retry outranks a STALL. The block also masks two buffer-control status bits, which always read zero on control endpoints.

Top module: `ep_stall_ctl`

## Requirements
- R1: After reset, stall_pending, stalled_flag, setup_flag, out_flag, ep_irq and hs_valid are 0 and hs_code is 0 (none).
- R2: stall_set raises stall_pending on the next cycle and stall_clr lowers it. When both are high in one cycle, stall_pending is 0 afterwards.
- R3: While stall_pending is 1, an OUT token (tok_kind 1) or an IN token (tok_kind 2) without retry_req is answered with hs_code 3 (STALL), and out_flag is not raised.
- R4: Every STALL answer sets stalled_flag on the same edge that hs_valid rises, and ep_irq follows.
- R5: A SETUP token (tok_kind 0) is answered with hs_code 1 (ACK) whatever retry_req and stall_pending are. It sets setup_flag and never out_flag.
- R6: A SETUP token with cfg_ctrl_ep = 1 clears both stall_pending and stalled_flag.
- R7: A SETUP token with cfg_ctrl_ep = 0 leaves stall_pending unchanged. Only stall_clr clears it.
- R8: An OUT or IN token with retry_req = 1 is answered with hs_code 2 (NAK), even while stall_pending is 1. It changes no flag.
- R9: With no retry and no pending STALL, an OUT token gets ACK and sets out_flag. An IN token gets ACK and sets no flag.
- R10: setup_clr, stalled_clr and out_clr lower their flags. A hardware event that sets a flag in the same cycle wins over its clear.
- R11: fifo_ctl_rd and rw_allowed_rd are 0 when cfg_ctrl_ep = 1. Otherwise they equal fifo_ctl_in and rw_allowed_in.
- R12: ep_irq is 1 exactly when at least one of stalled_flag, setup_flag or out_flag is 1.
- R13: hs_valid is a one-cycle pulse, one clock after each token with tok_kind 0 to 2. hs_code is 0 whenever hs_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl_ep | input | 1 | Endpoint is a control endpoint |
| stall_set | input | 1 | Strobe: arm STALL request |
| stall_clr | input | 1 | Strobe: disarm STALL request |
| tok_valid | input | 1 | Token event this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 OUT, 2 IN |
| retry_req | input | 1 | Buffer needs a retry (NAK) |
| setup_clr | input | 1 | Firmware clear of setup_flag |
| stalled_clr | input | 1 | Firmware clear of stalled_flag |
| out_clr | input | 1 | Firmware clear of out_flag |
| fifo_ctl_in | input | 1 | Raw buffer-control status bit |
| rw_allowed_in | input | 1 | Raw read/write-allowed status bit |
| hs_valid | output | 1 | Handshake decision pulse |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| stall_pending | output | 1 | STALL request armed |
| stalled_flag | output | 1 | A STALL was sent |
| setup_flag | output | 1 | A SETUP was accepted |
| out_flag | output | 1 | OUT data was accepted |
| ep_irq | output | 1 | Endpoint interrupt |
| fifo_ctl_rd | output | 1 | Masked buffer-control status |
| rw_allowed_rd | output | 1 | Masked read/write-allowed status |

## Verification
The hardest situations to reach are the ones where several causes meet in one cycle. Examples are a SETUP arriving with a STALL armed and a retry asserted, a STALL request armed and disarmed together, and a hardware flag set colliding with its firmware clear. The stimulus builds these step by step. It first arms a STALL, lets one STALL go out so the stalled flag is up, and only then presents the colliding token or strobes. It does this on both a control and a non-control endpoint, so that the SETUP-clears-STALL path is shown to apply only where it should.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_OUT   = 2'd1,
        TK_IN    = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef struct packed {
        logic stall;
        logic stalled;
    } stall_st_t;

    typedef struct packed {
        logic hs_valid;
        hs_e  hs_code;
        logic setup;
        logic out;
    } rx_st_t;

endpackage

// File: rtl/ep_hs_arbiter.sv
module ep_hs_arbiter
    import ep_hs_pkg::*;
(
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       retry_req,
    input  logic       stall_q,
    output hs_e        hs_sel,
    output logic       sent_stall,
    output logic       setup_seen,
    output logic       out_accepted
);

    tok_e kind;

    always_comb begin
        kind         = tok_e'(tok_kind);
        hs_sel       = HS_NONE;
        if (tok_valid) begin
            case (kind)
                TK_SETUP: hs_sel = HS_ACK;
                TK_OUT, TK_IN: begin
                    if (retry_req)    hs_sel = HS_NAK;
                    else if (stall_q) hs_sel = HS_STALL;
                    else              hs_sel = HS_ACK;
                end
                default: hs_sel = HS_NONE;
            endcase
        end
        sent_stall   = (hs_sel == HS_STALL);
        setup_seen   = tok_valid && (kind == TK_SETUP);
        out_accepted = tok_valid && (kind == TK_OUT) && (hs_sel == HS_ACK);
    end

endmodule

// File: rtl/ep_stall_state.sv
module ep_stall_state
    import ep_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall_set,
    input  logic stall_clr,
    input  logic setup_ctrl,
    input  logic sent_stall,
    input  logic stalled_clr,
    output logic stall_q,
    output logic stalled_q
);

    stall_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stall_clr || setup_ctrl)
            st_d.stall = 1'b0;
        else if (stall_set)
            st_d.stall = 1'b1;

        if (sent_stall)
            st_d.stalled = 1'b1;
        else if (setup_ctrl || stalled_clr)
            st_d.stalled = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_q   = st_q.stall;
    assign stalled_q = st_q.stalled;

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stall_clr |=> !stall_q);

    a_r6_setup_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ctrl |=> (!stall_q && !stalled_q));

    a_r2_set_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_set && !stall_clr && !setup_ctrl) |=> stall_q);

endmodule

// File: rtl/ep_rx_flags.sv
module ep_rx_flags
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  hs_e        hs_sel,
    input  logic       setup_seen,
    input  logic       out_accepted,
    input  logic       setup_clr,
    input  logic       out_clr,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       setup_q,
    output logic       out_q
);

    rx_st_t rx_d, rx_q;

    always_comb begin
        rx_d          = rx_q;
        rx_d.hs_valid = (hs_sel != HS_NONE);
        rx_d.hs_code  = hs_sel;
        if (setup_seen)      rx_d.setup = 1'b1;
        else if (setup_clr)  rx_d.setup = 1'b0;
        if (out_accepted)    rx_d.out = 1'b1;
        else if (out_clr)    rx_d.out = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '{hs_valid: 1'b0, hs_code: HS_NONE, setup: 1'b0, out: 1'b0};
        else        rx_q <= rx_d;
    end

    assign hs_valid = rx_q.hs_valid;
    assign hs_code  = rx_q.hs_code;
    assign setup_q  = rx_q.setup;
    assign out_q    = rx_q.out;

    a_r13_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_valid |-> (hs_code == 2'd0));

    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_seen && setup_clr) |=> setup_q);

endmodule

// File: rtl/ep_stall_ctl.sv
module ep_stall_ctl
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_ctrl_ep,
    input  logic       stall_set,
    input  logic       stall_clr,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       retry_req,
    input  logic       setup_clr,
    input  logic       stalled_clr,
    input  logic       out_clr,
    input  logic       fifo_ctl_in,
    input  logic       rw_allowed_in,
    output logic       hs_valid,
    output logic [1:0] hs_code,
    output logic       stall_pending,
    output logic       stalled_flag,
    output logic       setup_flag,
    output logic       out_flag,
    output logic       ep_irq,
    output logic       fifo_ctl_rd,
    output logic       rw_allowed_rd
);

    hs_e  hs_sel;
    logic sent_stall;
    logic setup_seen;
    logic out_accepted;
    logic stall_q;
    logic stalled_q;
    logic setup_q;
    logic out_q;

    ep_hs_arbiter arb_i (
        .tok_valid    (tok_valid),
        .tok_kind     (tok_kind),
        .retry_req    (retry_req),
        .stall_q      (stall_q),
        .hs_sel       (hs_sel),
        .sent_stall   (sent_stall),
        .setup_seen   (setup_seen),
        .out_accepted (out_accepted)
    );

    ep_stall_state stall_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_set   (stall_set),
        .stall_clr   (stall_clr),
        .setup_ctrl  (setup_seen && cfg_ctrl_ep),
        .sent_stall  (sent_stall),
        .stalled_clr (stalled_clr),
        .stall_q     (stall_q),
        .stalled_q   (stalled_q)
    );

    ep_rx_flags rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_sel       (hs_sel),
        .setup_seen   (setup_seen),
        .out_accepted (out_accepted),
        .setup_clr    (setup_clr),
        .out_clr      (out_clr),
        .hs_valid     (hs_valid),
        .hs_code      (hs_code),
        .setup_q      (setup_q),
        .out_q        (out_q)
    );

    assign stall_pending = stall_q;
    assign stalled_flag  = stalled_q;
    assign setup_flag    = setup_q;
    assign out_flag      = out_q;
    assign ep_irq        = stalled_q | setup_q | out_q;
    assign fifo_ctl_rd   = fifo_ctl_in   & ~cfg_ctrl_ep;
    assign rw_allowed_rd = rw_allowed_in & ~cfg_ctrl_ep;

    a_r5_setup_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd0) |=> (hs_valid && hs_code == 2'd1 && setup_flag));

    a_r8_retry_first: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (tok_kind == 2'd1 || tok_kind == 2'd2) && retry_req)
            |=> (hs_code == 2'd2));

    a_r4_stall_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'd3) |-> (stalled_flag && ep_irq));

    a_r3_no_out_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd1 && !retry_req && stall_pending && !out_flag && !out_clr)
            |=> !out_flag);

    a_r7_setup_keeps_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd0 && !cfg_ctrl_ep && stall_pending && !stall_clr)
            |=> stall_pending);

endmodule

// File: tb/ep_stall_ctl_tb_top.sv
module ep_stall_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_ctrl_ep, stall_set, stall_clr, tok_valid, retry_req;
    logic [1:0] tok_kind;
    logic       setup_clr, stalled_clr, out_clr, fifo_ctl_in, rw_allowed_in;
    logic       hs_valid, stall_pending, stalled_flag, setup_flag, out_flag, ep_irq;
    logic [1:0] hs_code;
    logic       fifo_ctl_rd, rw_allowed_rd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ep_stall_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl_ep(cfg_ctrl_ep),
        .stall_set(stall_set), .stall_clr(stall_clr),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .retry_req(retry_req),
        .setup_clr(setup_clr), .stalled_clr(stalled_clr), .out_clr(out_clr),
        .fifo_ctl_in(fifo_ctl_in), .rw_allowed_in(rw_allowed_in),
        .hs_valid(hs_valid), .hs_code(hs_code), .stall_pending(stall_pending),
        .stalled_flag(stalled_flag), .setup_flag(setup_flag), .out_flag(out_flag),
        .ep_irq(ep_irq), .fifo_ctl_rd(fifo_ctl_rd), .rw_allowed_rd(rw_allowed_rd)
    );

    // stimulus: ctrl set clr tv kind[2] retry sclr stclr oclr
    // expect:   hv code[2] stall stalled setup out irq
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        18'b1_1_0_0_00_0_0_0_0_0_00_1_0_0_0_0, // R2 arm
        18'b1_0_0_1_01_0_0_0_0_1_11_1_1_0_0_1, // R3 R4 OUT stalled
        18'b1_0_0_1_10_1_0_0_0_1_10_1_1_0_0_1, // R8 retry beats stall
        18'b1_0_0_0_00_0_0_1_0_0_00_1_0_0_0_0, // R10 stalled cleared
        18'b1_0_0_1_00_0_0_0_0_1_01_0_0_1_0_1, // R6 setup on control
        18'b1_0_0_1_01_0_0_0_0_1_01_0_0_1_1_1, // R9 OUT ack
        18'b1_0_0_0_00_0_1_0_1_0_00_0_0_0_0_0, // R10 flags cleared
        18'b1_1_1_0_00_0_0_0_0_0_00_0_0_0_0_0, // R2 clear wins
        18'b1_0_0_1_10_0_0_0_0_1_01_0_0_0_0_0, // R9 IN ack no flag
        18'b1_1_0_0_00_0_0_0_0_0_00_1_0_0_0_0, // R2 re-arm
        18'b0_0_0_1_00_0_0_0_0_1_01_1_0_1_0_1, // R7 setup keeps stall
        18'b0_0_0_1_10_0_0_0_0_1_11_1_1_1_0_1, // R3 IN stalled
        18'b0_0_1_0_00_0_0_0_0_0_00_0_1_1_0_1  // R2 clear strobe
    };
    localparam string VREQ [NV] = '{"R2","R3","R8","R10","R6","R9","R10",
                                    "R2","R9","R2","R7","R3","R2"};

    function automatic logic [6:0] observed();
        return {hs_valid, hs_code, stall_pending, stalled_flag, setup_flag, out_flag};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        stall_set = 0; stall_clr = 0; tok_valid = 0; tok_kind = 0; retry_req = 0;
        setup_clr = 0; stalled_clr = 0; out_clr = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        cfg_ctrl_ep = 1; fifo_ctl_in = 0; rw_allowed_in = 0;
        do_reset();
        // R1 reset state (ep_irq appended as bit 0)
        check("R1", {1'b0, observed(), ep_irq}, 8'b0);

        for (int i = 0; i < NV; i++) begin
            {cfg_ctrl_ep, stall_set, stall_clr, tok_valid, tok_kind, retry_req,
             setup_clr, stalled_clr, out_clr} = VEC[i][17:8];
            @(negedge clk);
            idle_inputs();
            check(VREQ[i], {1'b0, observed(), ep_irq}, {1'b0, VEC[i][7:0]});
            // R12 irq against flags
            check("R12", {7'b0, ep_irq}, {7'b0, stalled_flag | setup_flag | out_flag});
        end

        // R13 pulse is one cycle long
        @(negedge clk);
        check("R13", {5'b0, hs_valid, hs_code}, 8'b0);

        // R5 SETUP with stall armed and retry on control endpoint -> ACK
        do_reset();
        cfg_ctrl_ep = 1; stall_set = 1; @(negedge clk); idle_inputs();
        tok_valid = 1; tok_kind = 0; retry_req = 1; @(negedge clk); idle_inputs();
        check("R5", {1'b0, observed(), ep_irq}, 8'b1_01_0_0_1_0_1);

        // R10 OUT accept with same-cycle out_clr: set wins
        tok_valid = 1; tok_kind = 1; out_clr = 1; @(negedge clk); idle_inputs();
        check("R10", {7'b0, out_flag}, 8'd1);
        // R10 setup accept with setup_clr same cycle
        tok_valid = 1; tok_kind = 0; setup_clr = 1; @(negedge clk); idle_inputs();
        check("R10", {7'b0, setup_flag}, 8'd1);

        // R4 stalled set wins over stalled_clr
        stall_set = 1; @(negedge clk); idle_inputs();
        tok_valid = 1; tok_kind = 2; stalled_clr = 1; @(negedge clk); idle_inputs();
        check("R4", {5'b0, hs_code, stalled_flag}, 8'b0000_0111);

        // R13 reserved token kind gives no handshake
        tok_valid = 1; tok_kind = 3; @(negedge clk); idle_inputs();
        check("R13", {5'b0, hs_valid, hs_code}, 8'b0);

        // R11 masking of buffer status bits
        fifo_ctl_in = 1; rw_allowed_in = 1; cfg_ctrl_ep = 1; #1;
        check("R11", {6'b0, fifo_ctl_rd, rw_allowed_rd}, 8'b0);
        cfg_ctrl_ep = 0; #1;
        check("R11", {6'b0, fifo_ctl_rd, rw_allowed_rd}, 8'b11);
        fifo_ctl_in = 0; #1;
        check("R11", {6'b0, fifo_ctl_rd, rw_allowed_rd}, 8'b01);

        // R1 reset mid-run clears everything
        do_reset();
        check("R1", {1'b0, observed(), ep_irq}, 8'b0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule